// File: doc/BRIEF.md
# I2C Master Register and Interrupt Block

This block is the software-facing side of a FIFO-based I2C master. A simple 32-bit read/write bus reaches a small set of word registers. Through them, software loads byte commands into the engine's command FIFO, drains received bytes from the receive FIFO, and sets the core enable, the bus speed and the two FIFO thresholds. It also programs three timing counts that the bit engine uses for SCL low time, SCL high time and SDA hold.

The block raises one interrupt line. Two level-driven "ready" conditions come from the FIFO fill levels. Three sticky error flags are latched from single-cycle event pulses sent by the engine. Each status bit has an enable bit, and the line is asserted while any enabled status bit is set. The engine sits outside this block and connects through push/pop strobes, level inputs and event pulses. While the enable bit is low, the engine is held in reset and all status is cleared, so clearing the enable bit and then setting it again restarts the controller from a clean state.

Top module: `i2cm_regs`

## Requirements
- R1: After reset, the control, interrupt-enable, interrupt-status and timing registers are all zero, irq is 0, bus_rdata is 0, and core_rst is 1.
- R2: Word offset 0x08 holds the control register. Bit 0 is core enable, bit 1 is fast speed, bits 3:2 are the command threshold and bits 5:4 are the receive threshold. It reads back as written, and its fields drive core_enable and bus_fast.
- R3: Offsets 0x20 (SCL low), 0x24 (SCL high) and 0x28 (SDA hold) are 16-bit registers. Each one reads back its value and drives its output.
- R4: A write to 0x00 pulses cmd_push for one cycle, with cmd_data = bus_wdata[9:0] (bit 9 start, bit 8 stop, bits 7:0 byte). The write is dropped when the core is disabled or when cmd_level equals the FIFO depth (4).
- R5: A read of 0x04 with rx_level > 0 returns rx_head zero-extended and pulses rx_pop once. With rx_level = 0, the read returns 0 and does not pop.
- R6: Status bit 0 (TX ready) is set while cmd_level <= command threshold. Status bit 1 (RX ready) is set while rx_level > receive threshold. Both re-assert after a clear if the condition still holds.
- R7: Status bits 2 (NACK), 3 (arbitration lost) and 4 (RX overflow) are set by pulses on ev_nack, ev_arb and ev_rx_ovf while the core is enabled, and they stay set until cleared.
- R8: A write to 0x10 clears each status bit whose data bit is 1 and leaves the others unchanged.
- R9: Offset 0x0C holds a 5-bit interrupt enable with the same bit positions as status. irq is 1 exactly when some status bit and its enable bit are both 1.
- R10: While core enable is 0, core_rst is 1, all status bits read 0 and event pulses are ignored.
- R11: Offset 0x14 bit 0 reads core_busy, 0x18 reads cmd_level and 0x1C reads rx_level. Unmapped offsets read 0.
- R12: A read returns its data in bus_rdata one clock after bus_rd is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| cmd_push | output | 1 | Push strobe to command FIFO |
| cmd_data | output | 10 | Command word: start, stop, byte |
| cmd_level | input | 3 | Command FIFO fill level |
| rx_pop | output | 1 | Pop strobe to receive FIFO |
| rx_head | input | 8 | Head entry of receive FIFO |
| rx_level | input | 3 | Receive FIFO fill level |
| core_busy | input | 1 | Engine busy flag |
| ev_nack | input | 1 | NACK event pulse |
| ev_arb | input | 1 | Arbitration-lost event pulse |
| ev_rx_ovf | input | 1 | Receive overflow event pulse |
| core_enable | output | 1 | Core enable field |
| bus_fast | output | 1 | Fast speed field |
| core_rst | output | 1 | Engine reset, high while disabled |
| scl_low_cnt | output | 16 | SCL low count |
| scl_high_cnt | output | 16 | SCL high count |
| sda_hold_cnt | output | 16 | SDA hold count |
| irq | output | 1 | Interrupt request |

## Verification
The random part of the bench draws FIFO levels, both thresholds, event subsets and enable masks. This separates a wrong comparison direction or an off-by-one in either ready rule from a wrong status bit position or a mis-masked interrupt. Directed cases cover the edges of each rule. A full command FIFO and a disabled core show that a push is gated. An empty receive FIFO shows the zero read with no pop. A partial clear shows that write-one-to-clear is applied per bit. Clearing a ready bit while its condition holds shows that it re-asserts. A disable and re-enable sequence shows that the sticky errors are wiped.

// File: rtl/i2cm_regs_pkg.sv
package i2cm_regs_pkg;
  localparam int DATA_W = 32;
  localparam int NIRQ   = 5;
  localparam int CMD_W  = 10;

  // word indices (byte offset / 4)
  localparam int IX_CMD   = 0;
  localparam int IX_RXD   = 1;
  localparam int IX_CTL   = 2;
  localparam int IX_IEN   = 3;
  localparam int IX_IST   = 4;
  localparam int IX_STAT  = 5;
  localparam int IX_CLVL  = 6;
  localparam int IX_RLVL  = 7;
  localparam int IX_SLOW  = 8;
  localparam int IX_SHIGH = 9;
  localparam int IX_HOLD  = 10;

  // status / enable bit positions
  localparam int B_TXR  = 0;
  localparam int B_RXR  = 1;
  localparam int B_NACK = 2;
  localparam int B_ARB  = 3;
  localparam int B_OVF  = 4;

  function automatic logic tx_ready_f(input logic [7:0] lvl, input logic [1:0] thr);
    return lvl <= {6'b0, thr};
  endfunction

  function automatic logic rx_ready_f(input logic [7:0] lvl, input logic [1:0] thr);
    return lvl > {6'b0, thr};
  endfunction

  function automatic logic irq_f(input logic [NIRQ-1:0] st, input logic [NIRQ-1:0] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/i2cm_fifo_port.sv
module i2cm_fifo_port #(
  parameter int LVL_W      = 3,
  parameter int FIFO_DEPTH = 4,
  parameter int CMD_W      = 10
) (
  input  logic             wr_cmd,
  input  logic             rd_rx,
  input  logic             core_en,
  input  logic [CMD_W-1:0] wdata,
  input  logic [LVL_W-1:0] cmd_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [7:0]       rx_head,
  output logic             cmd_push,
  output logic [CMD_W-1:0] cmd_data,
  output logic             rx_pop,
  output logic [7:0]       rx_word
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic rx_has_data;
  assign rx_has_data = (rx_level != '0);

  assign cmd_push = wr_cmd & core_en & (cmd_level < FULL_LVL);
  assign cmd_data = wdata;
  assign rx_pop   = rd_rx & rx_has_data;
  assign rx_word  = rx_has_data ? rx_head : 8'h00;
endmodule

// File: rtl/i2cm_irq_unit.sv
module i2cm_irq_unit
  import i2cm_regs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_en,
  input  logic            tx_rdy,
  input  logic            rx_rdy,
  input  logic            ev_nack,
  input  logic            ev_arb,
  input  logic            ev_rx_ovf,
  input  logic [NIRQ-1:0] w1c_mask,
  input  logic [NIRQ-1:0] ien_q,
  output logic [NIRQ-1:0] status_q,
  output logic            irq
);
  logic [NIRQ-1:0] set_vec;
  assign set_vec[B_TXR]  = tx_rdy;
  assign set_vec[B_RXR]  = rx_rdy;
  assign set_vec[B_NACK] = ev_nack;
  assign set_vec[B_ARB]  = ev_arb;
  assign set_vec[B_OVF]  = ev_rx_ovf;

  for (genvar i = 0; i < NIRQ; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        status_q[i] <= 1'b0;
      else if (!core_en) status_q[i] <= 1'b0;
      else               status_q[i] <= (status_q[i] & ~w1c_mask[i]) | set_vec[i];
    end
  end

  assign irq = irq_f(status_q, ien_q);
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_regs_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LVL_W      = 3,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cmd_push,
  output logic [9:0]        cmd_data,
  input  logic [LVL_W-1:0]  cmd_level,
  output logic              rx_pop,
  input  logic [7:0]        rx_head,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              core_busy,
  input  logic              ev_nack,
  input  logic              ev_arb,
  input  logic              ev_rx_ovf,
  output logic              core_enable,
  output logic              bus_fast,
  output logic              core_rst,
  output logic [CNT_W-1:0]  scl_low_cnt,
  output logic [CNT_W-1:0]  scl_high_cnt,
  output logic [CNT_W-1:0]  sda_hold_cnt,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             word_ok, wr_hit, rd_hit;
  logic [5:0]       ctl_q;
  logic [NIRQ-1:0]  ien_q, status_q, w1c_mask;
  logic             core_en_w, tx_rdy, rx_rdy;
  logic [7:0]       rx_word;
  logic [31:0]      rd_mux;
  logic             unused_hi;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign word_ok = (bus_addr[1:0] == 2'b00);
  assign wr_hit  = bus_wr & word_ok;
  assign rd_hit  = bus_rd & word_ok;
  assign unused_hi = ^bus_wdata[31:CNT_W];

  assign core_en_w   = ctl_q[0];
  assign core_enable = ctl_q[0];
  assign bus_fast    = ctl_q[1];
  assign core_rst    = ~ctl_q[0];

  // writable registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q        <= '0;
      ien_q        <= '0;
      scl_low_cnt  <= '0;
      scl_high_cnt <= '0;
      sda_hold_cnt <= '0;
    end else if (wr_hit) begin
      if (idx == IDX_W'(IX_CTL))   ctl_q        <= bus_wdata[5:0];
      if (idx == IDX_W'(IX_IEN))   ien_q        <= bus_wdata[NIRQ-1:0];
      if (idx == IDX_W'(IX_SLOW))  scl_low_cnt  <= bus_wdata[CNT_W-1:0];
      if (idx == IDX_W'(IX_SHIGH)) scl_high_cnt <= bus_wdata[CNT_W-1:0];
      if (idx == IDX_W'(IX_HOLD))  sda_hold_cnt <= bus_wdata[CNT_W-1:0];
    end
  end

  assign w1c_mask = (wr_hit && idx == IDX_W'(IX_IST)) ? bus_wdata[NIRQ-1:0] : '0;
  assign tx_rdy   = tx_ready_f(8'(cmd_level), ctl_q[3:2]);
  assign rx_rdy   = rx_ready_f(8'(rx_level), ctl_q[5:4]);

  i2cm_fifo_port #(.LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH), .CMD_W(CMD_W)) u_port (
    .wr_cmd   (wr_hit && idx == IDX_W'(IX_CMD)),
    .rd_rx    (rd_hit && idx == IDX_W'(IX_RXD)),
    .core_en  (core_en_w),
    .wdata    (bus_wdata[CMD_W-1:0]),
    .cmd_level(cmd_level),
    .rx_level (rx_level),
    .rx_head  (rx_head),
    .cmd_push (cmd_push),
    .cmd_data (cmd_data),
    .rx_pop   (rx_pop),
    .rx_word  (rx_word)
  );

  i2cm_irq_unit u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_en  (core_en_w),
    .tx_rdy   (tx_rdy),
    .rx_rdy   (rx_rdy),
    .ev_nack  (ev_nack),
    .ev_arb   (ev_arb),
    .ev_rx_ovf(ev_rx_ovf),
    .w1c_mask (w1c_mask),
    .ien_q    (ien_q),
    .status_q (status_q),
    .irq      (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (idx)
      IDX_W'(IX_RXD):   rd_mux = 32'(rx_word);
      IDX_W'(IX_CTL):   rd_mux = 32'(ctl_q);
      IDX_W'(IX_IEN):   rd_mux = 32'(ien_q);
      IDX_W'(IX_IST):   rd_mux = 32'(status_q);
      IDX_W'(IX_STAT):  rd_mux = 32'(core_busy);
      IDX_W'(IX_CLVL):  rd_mux = 32'(cmd_level);
      IDX_W'(IX_RLVL):  rd_mux = 32'(rx_level);
      IDX_W'(IX_SLOW):  rd_mux = 32'(scl_low_cnt);
      IDX_W'(IX_SHIGH): rd_mux = 32'(scl_high_cnt);
      IDX_W'(IX_HOLD):  rd_mux = 32'(sda_hold_cnt);
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/i2cm_regs_chk.sv
module i2cm_regs_chk #(
  parameter int LVL_W      = 3,
  parameter int FIFO_DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_en,
  input logic [4:0]       status_q,
  input logic [4:0]       w1c_mask,
  input logic             ev_nack,
  input logic             cmd_push,
  input logic             rx_pop,
  input logic [LVL_W-1:0] cmd_level,
  input logic [LVL_W-1:0] rx_level
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  // R7
  nack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack && ctl_en |=> status_q[2]);
  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[3] && !w1c_mask[3] && ctl_en |=> status_q[3]);
  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[2] && w1c_mask[2] && !ev_nack |=> !status_q[2]);
  // R10
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> status_q == 5'b0);
  // R4
  push_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push |-> ctl_en && (cmd_level < FULL_LVL));
  // R5
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_level != '0);
endmodule

bind i2cm_regs i2cm_regs_chk #(.LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_en   (core_en_w),
  .status_q (status_q),
  .w1c_mask (w1c_mask),
  .ev_nack  (ev_nack),
  .cmd_push (cmd_push),
  .rx_pop   (rx_pop),
  .cmd_level(cmd_level),
  .rx_level (rx_level)
);

// File: tb/tb_i2cm_regs.sv
`timescale 1ns/1ps
module tb_i2cm_regs;
  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        cmd_push, rx_pop, core_enable, bus_fast, core_rst, irq;
  logic [9:0]  cmd_data;
  logic [2:0]  cmd_level = 0, rx_level = 0;
  logic [7:0]  rx_head = 0;
  logic        core_busy = 0, ev_nack = 0, ev_arb = 0, ev_rx_ovf = 0;
  logic [15:0] scl_low_cnt, scl_high_cnt, sda_hold_cnt;

  int n_chk = 0, n_fail = 0, push_cnt = 0, pop_cnt = 0;
  logic [9:0] last_push = 0;

  always #2.5 clk = ~clk;

  i2cm_regs dut (.*);

  always @(posedge clk) begin
    if (cmd_push) begin push_cnt++; last_push = cmd_data; end
    if (rx_pop) pop_cnt++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [2:0] evs);
    @(negedge clk); {ev_rx_ovf, ev_arb, ev_nack} = evs;
    @(negedge clk); {ev_rx_ovf, ev_arb, ev_nack} = 3'b0;
  endtask

  function automatic logic m_tx(input int lvl, input int thr); return lvl <= thr; endfunction
  function automatic logic m_rx(input int lvl, input int thr); return lvl > thr; endfunction

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int p0;
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(bus_rdata == 0 && irq == 0 && core_rst == 1 && core_enable == 0, "R1 reset outputs",
          {irq, core_rst, core_enable}, 32'h2);
    rst_n = 1;
    rd(6'h08, d); check(d == 0, "R1 ctl reset", d, 0);
    rd(6'h10, d); check(d == 0, "R1 status reset", d, 0);
    rd(6'h20, d); check(d == 0, "R1 timing reset", d, 0);

    // R10 disabled: events ignored, push ignored
    pulse(3'b111);
    rd(6'h10, d); check(d == 0, "R10 events ignored while disabled", d, 0);
    p0 = push_cnt; wr(6'h00, 32'h2A5);
    check(push_cnt == p0, "R4 push dropped while disabled", push_cnt, p0);

    // R2 control readback
    wr(6'h08, 32'h3B);
    rd(6'h08, d); check(d == 32'h3B, "R2 ctl readback", d, 32'h3B);
    check(core_enable == 1 && bus_fast == 1 && core_rst == 0, "R2 ctl fields", {core_enable, bus_fast, core_rst}, 3'b110);

    // R3 timing counts
    wr(6'h20, 32'hFFFF_1234); wr(6'h24, 32'h0000_0ABC); wr(6'h28, 32'h0000_001E);
    rd(6'h20, d); check(d == 32'h1234 && scl_low_cnt == 16'h1234, "R3 scl low", d, 32'h1234);
    rd(6'h24, d); check(d == 32'h0ABC && scl_high_cnt == 16'h0ABC, "R3 scl high", d, 32'h0ABC);
    rd(6'h28, d); check(d == 32'h1E && sda_hold_cnt == 16'h1E, "R3 sda hold", d, 32'h1E);

    // R4 push
    cmd_level = 3; p0 = push_cnt; wr(6'h00, 32'hFFFF_F2A5);
    check(push_cnt == p0 + 1 && last_push == 10'h2A5, "R4 push data", {22'b0, last_push}, 32'h2A5);
    cmd_level = 4; p0 = push_cnt; wr(6'h00, 32'h1);
    check(push_cnt == p0, "R4 push dropped when full", push_cnt, p0);

    // R5 pop
    rx_level = 2; rx_head = 8'h5C; p0 = pop_cnt;
    rd(6'h04, d); check(d == 32'h5C && pop_cnt == p0 + 1, "R5 rx read pops", d, 32'h5C);
    rx_level = 0; p0 = pop_cnt;
    rd(6'h04, d); check(d == 0 && pop_cnt == p0, "R5 empty read", d, 0);

    // R11 status and levels
    core_busy = 1; cmd_level = 3; rx_level = 2;
    rd(6'h14, d); check(d == 1, "R11 busy", d, 1);
    rd(6'h18, d); check(d == 3, "R11 cmd level", d, 3);
    rd(6'h1C, d); check(d == 2, "R11 rx level", d, 2);
    rd(6'h2C, d); check(d == 0, "R11 unmapped", d, 0);
    core_busy = 0;

    // R6 ready re-asserts after clear: thresholds cmd=2 rx=3, levels cmd=1 rx=0
    wr(6'h08, 32'h39); cmd_level = 1; rx_level = 0;
    wr(6'h10, 32'h1F);
    rd(6'h10, d); check(d == 32'h1, "R6 tx ready re-asserts", d, 1);

    // R7 sticky, R8 partial clear
    cmd_level = 4;
    pulse(3'b011); wr(6'h10, 32'h1);
    rd(6'h10, d); check(d == 32'h0C, "R7 sticky nack+arb", d, 32'h0C);
    wr(6'h10, 32'h04);
    rd(6'h10, d); check(d == 32'h08, "R8 partial clear", d, 32'h08);

    // R9 irq masking
    wr(6'h0C, 32'h04); @(negedge clk);
    check(irq == 0, "R9 masked", irq, 0);
    wr(6'h0C, 32'h08); @(negedge clk);
    check(irq == 1, "R9 enabled", irq, 1);
    rd(6'h0C, d); check(d == 32'h08, "R9 ien readback", d, 8);

    // R10 disable wipes, re-enable clean
    wr(6'h08, 32'h38); @(negedge clk);
    check(core_rst == 1 && irq == 0, "R10 disable resets", {core_rst, irq}, 2'b10);
    wr(6'h08, 32'h39);
    rd(6'h10, d); check(d == 0, "R10 re-enable clean status", d, 0);

    // R6 R7 R9 R12 random
    for (int it = 0; it < 60; it++) begin
      int cl, rl, ct, rt;
      logic [2:0] evs;
      logic [4:0] ie, exp;
      cl = $urandom % 5; rl = $urandom % 5; ct = $urandom % 4; rt = $urandom % 4;
      evs = 3'($urandom); ie = 5'($urandom);
      @(negedge clk); cmd_level = 3'(cl); rx_level = 3'(rl);
      wr(6'h08, 32'(rt * 16 + ct * 4 + 1));
      wr(6'h0C, 32'(ie));
      wr(6'h10, 32'h1F);
      pulse(evs);
      exp = {evs, m_rx(rl, rt), m_tx(cl, ct)};
      rd(6'h10, d);
      check(d == 32'(exp), "R6 R7 random status", d, 32'(exp));
      check(irq == |(exp & ie), "R9 random irq", irq, |(exp & ie));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule